// File: doc/BRIEF.md
# UART Channel Loopback Mode Router

This block sits between one UART channel's shift engines and its two serial pins. It steers the serial data and the per-bit timing enables according to a 2-bit channel mode. The four modes are: independent operation, automatic echo, local loopback and remote loopback. It also gates the transmitter status flags, the CPU transmit enable and the hand-off of received characters, so that each mode presents a consistent picture to software.

In automatic echo and remote loopback, the pin-side receive line is sampled on the receive mid-bit tick. The sampled level is then held on the transmit pin for one full bit time. Parity, stop bits and break therefore go back out exactly as they arrived. Two frame trackers watch the receive pin and the transmitter's serial output, and a requested mode is adopted only while both lines are between characters. The block moves single serial bits, not words, so no data port here is a valid/ready stream. Every pin is plain and acts in the cycle it is sampled.

Top module: `uart_loop_router`

## Requirements
- R1: Mode code 2'b00 (normal): txd_pin follows tx_ser_i, rx_ser_o follows rxd_pin, and each engine gets its own tick (tx_tick_o = tx_bit_tick_i, rx_tick_o = rx_bit_tick_i). The flags, the CPU transmit enable and rx_hand_o = 1 pass unchanged.
- R2: Mode code 2'b01 (automatic echo): txd_pin is the level of rxd_pin captured on the last rx_bit_tick_i, held until the next one. The transmit engine is timed by the receive tick (tx_tick_o = rx_bit_tick_i).
- R3: In automatic echo, cpu_tx_en_o, tx_rdy_o and tx_emt_o are forced to 0 whatever their inputs. Received characters are still handed on (rx_hand_o = 1, rx_ser_o = rxd_pin).
- R4: Mode code 2'b10 (local loopback): rx_ser_o follows tx_ser_i and rx_tick_o = tx_bit_tick_i. txd_pin is held at 1, and rxd_pin has no effect on any routed output. The flags and the CPU transmit enable pass unchanged.
- R5: Mode code 2'b11 (remote loopback): txd_pin carries the same re-clocked receive level as in echo, timed by rx_bit_tick_i. rx_hand_o is 0. The flags and the CPU transmit enable pass unchanged.
- R6: A frame starts when a line's tick samples 0 while its tracker is idle, and the frame lasts FRAME_BITS ticks, start bit included. The applied mode takes the value of mode_req at a clock edge only when neither tracker is busy and neither line starts a frame in that cycle. Otherwise the previous mode is kept.
- R7: During reset the applied mode is normal, both trackers are idle and the re-clocked echo level is 1 (mark).
- R8: A receive line held at 0 (break) in echo mode is repeated as 0 on txd_pin for as long as it lasts, and the line returns to 1 once rxd_pin is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested channel mode (00 normal, 01 echo, 10 local, 11 remote) |
| rxd_pin | input | 1 | External receive line, already synchronised to clk |
| txd_pin | output | 1 | External transmit line |
| tx_ser_i | input | 1 | Serial output of the transmit engine |
| rx_ser_o | output | 1 | Serial input presented to the receive engine |
| tx_bit_tick_i | input | 1 | Transmit bit-time enable, one-cycle pulse |
| rx_bit_tick_i | input | 1 | Receive mid-bit enable, one-cycle pulse |
| tx_tick_o | output | 1 | Bit enable delivered to the transmit engine |
| rx_tick_o | output | 1 | Bit enable delivered to the receive engine |
| cpu_tx_en_i | input | 1 | CPU request to load the transmitter |
| cpu_tx_en_o | output | 1 | Gated CPU transmit enable |
| tx_rdy_i | input | 1 | Transmitter ready flag from the engine |
| tx_emt_i | input | 1 | Transmitter empty flag from the engine |
| tx_rdy_o | output | 1 | Transmitter ready flag shown to the CPU |
| tx_emt_o | output | 1 | Transmitter empty flag shown to the CPU |
| rx_hand_o | output | 1 | High when received characters may be passed to the CPU |

## Verification
The assertions assume that both tick inputs are single-cycle pulses. They also assume that rxd_pin and tx_ser_i are synchronous to clk and settle between ticks, so each tracker counts exactly one bit per tick. The stimulus drives every input just after the falling edge and spaces the receive ticks four cycles apart and the transmit ticks five cycles apart. It changes each serial line only on cycles without its tick, and it mixes random bits, idle stretches and long breaks. Mode requests change at random instants, both mid-frame and during idle gaps, so the idle-only switching rule is exercised in both directions.

// File: rtl/uartlb_pkg.sv
package uartlb_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ECHO   = 2'b01,
    MODE_LOCAL  = 2'b10,
    MODE_REMOTE = 2'b11
  } chan_mode_e;
endpackage

// File: rtl/uartlb_frame_track.sv
module uartlb_frame_track #(
  parameter int FRAME_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  output logic idle_o
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] left_q;
  logic          start_now;

  assign start_now = tick_i && !line_i && (left_q == '0);
  assign idle_o    = (left_q == '0) && !start_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (tick_i) begin
      if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end else if (!line_i) begin
        left_q <= LAST;
      end
    end
  end

  // R6: a start bit arms a full frame
  a_r6_frame_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0 && tick_i && !line_i) |=> (left_q == LAST));
  // R6: each tick inside a frame consumes one bit
  a_r6_frame_count: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0 && tick_i) |=> (left_q == $past(left_q) - 1'b1));
  // R6: no tick, no progress
  a_r6_frame_still: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(left_q));
endmodule

// File: rtl/uartlb_reclock.sv
module uartlb_reclock (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick_i,
  input  logic line_i,
  output logic level_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
    end else if (sample_tick_i) begin
      level_q <= line_i;
    end
  end

  assign level_o = level_q;

  // R2: the sampled level is held for the whole bit time
  a_r2_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick_i |=> $stable(level_o));
  // R2: mid-bit tick captures the line
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick_i |=> (level_o == $past(line_i)));
endmodule

// File: rtl/uartlb_mode_gate.sv
module uartlb_mode_gate
  import uartlb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req_i,
  input  logic       rx_idle_i,
  input  logic       tx_idle_i,
  output chan_mode_e mode_o
);
  chan_mode_e mode_q;
  logic       may_switch;

  assign may_switch = rx_idle_i && tx_idle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
    end else if (may_switch) begin
      mode_q <= chan_mode_e'(mode_req_i);
    end
  end

  assign mode_o = mode_q;

  // R6: the applied mode only moves across an idle gap
  a_r6_switch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> $past(rx_idle_i && tx_idle_i));
  // R6: a busy line freezes the mode
  a_r6_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_idle_i && tx_idle_i) |=> $stable(mode_o));
endmodule

// File: rtl/uartlb_route.sv
module uartlb_route
  import uartlb_pkg::*;
(
  input  chan_mode_e mode_i,
  input  logic       rxd_pin_i,
  input  logic       tx_ser_i,
  input  logic       echo_level_i,
  input  logic       tx_bit_tick_i,
  input  logic       rx_bit_tick_i,
  input  logic       cpu_tx_en_i,
  input  logic       tx_rdy_i,
  input  logic       tx_emt_i,
  output logic       txd_o,
  output logic       rx_ser_o,
  output logic       tx_tick_o,
  output logic       rx_tick_o,
  output logic       cpu_tx_en_o,
  output logic       tx_rdy_o,
  output logic       tx_emt_o,
  output logic       rx_hand_o
);
  always_comb begin
    txd_o       = tx_ser_i;
    rx_ser_o    = rxd_pin_i;
    tx_tick_o   = tx_bit_tick_i;
    rx_tick_o   = rx_bit_tick_i;
    cpu_tx_en_o = cpu_tx_en_i;
    tx_rdy_o    = tx_rdy_i;
    tx_emt_o    = tx_emt_i;
    rx_hand_o   = 1'b1;
    unique case (mode_i)
      MODE_NORMAL: begin
      end
      MODE_ECHO: begin
        txd_o       = echo_level_i;
        tx_tick_o   = rx_bit_tick_i;
        cpu_tx_en_o = 1'b0;
        tx_rdy_o    = 1'b0;
        tx_emt_o    = 1'b0;
      end
      MODE_LOCAL: begin
        txd_o     = 1'b1;
        rx_ser_o  = tx_ser_i;
        rx_tick_o = tx_bit_tick_i;
      end
      MODE_REMOTE: begin
        txd_o     = echo_level_i;
        tx_tick_o = rx_bit_tick_i;
        rx_hand_o = 1'b0;
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/uart_loop_router.sv
module uart_loop_router
  import uartlb_pkg::*;
#(
  parameter int FRAME_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       rxd_pin,
  output logic       txd_pin,
  input  logic       tx_ser_i,
  output logic       rx_ser_o,
  input  logic       tx_bit_tick_i,
  input  logic       rx_bit_tick_i,
  output logic       tx_tick_o,
  output logic       rx_tick_o,
  input  logic       cpu_tx_en_i,
  output logic       cpu_tx_en_o,
  input  logic       tx_rdy_i,
  input  logic       tx_emt_i,
  output logic       tx_rdy_o,
  output logic       tx_emt_o,
  output logic       rx_hand_o
);
  logic       rx_idle, tx_idle, echo_level;
  chan_mode_e mode_now;

  uartlb_frame_track #(.FRAME_BITS(FRAME_BITS)) u_rx_track (
    .clk(clk), .rst_n(rst_n), .tick_i(rx_bit_tick_i), .line_i(rxd_pin),
    .idle_o(rx_idle));

  uartlb_frame_track #(.FRAME_BITS(FRAME_BITS)) u_tx_track (
    .clk(clk), .rst_n(rst_n), .tick_i(tx_bit_tick_i), .line_i(tx_ser_i),
    .idle_o(tx_idle));

  uartlb_reclock u_reclock (
    .clk(clk), .rst_n(rst_n), .sample_tick_i(rx_bit_tick_i),
    .line_i(rxd_pin), .level_o(echo_level));

  uartlb_mode_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode_req_i(mode_req),
    .rx_idle_i(rx_idle), .tx_idle_i(tx_idle), .mode_o(mode_now));

  uartlb_route u_route (
    .mode_i(mode_now), .rxd_pin_i(rxd_pin), .tx_ser_i(tx_ser_i),
    .echo_level_i(echo_level), .tx_bit_tick_i(tx_bit_tick_i),
    .rx_bit_tick_i(rx_bit_tick_i), .cpu_tx_en_i(cpu_tx_en_i),
    .tx_rdy_i(tx_rdy_i), .tx_emt_i(tx_emt_i), .txd_o(txd_pin),
    .rx_ser_o(rx_ser_o), .tx_tick_o(tx_tick_o), .rx_tick_o(rx_tick_o),
    .cpu_tx_en_o(cpu_tx_en_o), .tx_rdy_o(tx_rdy_o), .tx_emt_o(tx_emt_o),
    .rx_hand_o(rx_hand_o));

  // R1: normal mode passes both directions straight through
  a_r1_normal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_NORMAL) |-> (txd_pin == tx_ser_i && rx_ser_o == rxd_pin));
  // R3: echo hides the transmitter from the CPU
  a_r3_echo_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_ECHO) |-> (!tx_rdy_o && !tx_emt_o && !cpu_tx_en_o));
  // R4: local loopback keeps the pin at mark
  a_r4_local_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_LOCAL) |-> (txd_pin && rx_ser_o == tx_ser_i));
  // R5: remote loopback withholds received characters
  a_r5_remote_nohand: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_REMOTE) |-> (!rx_hand_o && txd_pin == echo_level));
endmodule

// File: tb/uart_loop_router_test.sv
`timescale 1ns/1ps
module uart_loop_router_test;
  localparam int FB = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic rxd = 1'b1, tx_ser = 1'b1, txt = 1'b0, rxt = 1'b0;
  logic cpu_en = 1'b0, rdy = 1'b0, emt = 1'b0;
  logic txd_pin, rx_ser_o, tx_tick_o, rx_tick_o, cpu_tx_en_o;
  logic tx_rdy_o, tx_emt_o, rx_hand_o;

  int checks = 0, fails = 0;
  bit done = 0, brk = 0;

  // reference model state
  int m_mode = 0, m_rxc = 0, m_txc = 0;
  bit m_echo = 1;

  always #2.5 clk = ~clk;

  uart_loop_router #(.FRAME_BITS(FB)) uut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .rxd_pin(rxd),
    .txd_pin(txd_pin), .tx_ser_i(tx_ser), .rx_ser_o(rx_ser_o),
    .tx_bit_tick_i(txt), .rx_bit_tick_i(rxt), .tx_tick_o(tx_tick_o),
    .rx_tick_o(rx_tick_o), .cpu_tx_en_i(cpu_en), .cpu_tx_en_o(cpu_tx_en_o),
    .tx_rdy_i(rdy), .tx_emt_i(emt), .tx_rdy_o(tx_rdy_o),
    .tx_emt_o(tx_emt_o), .rx_hand_o(rx_hand_o));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rxc = 0; m_txc = 0; m_echo = 1;
    end else begin
      bit rs, ts;
      rs = rxt && !rxd && m_rxc == 0;
      ts = txt && !tx_ser && m_txc == 0;
      if (m_rxc == 0 && m_txc == 0 && !rs && !ts) m_mode = mode_req;
      if (rxt) begin
        if (m_rxc != 0) m_rxc--; else if (!rxd) m_rxc = FB - 1;
        m_echo = rxd;
      end
      if (txt) begin
        if (m_txc != 0) m_txc--; else if (!tx_ser) m_txc = FB - 1;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit e_txd, e_rxs, e_txt, e_rxt, e_ce, e_rdy, e_emt, e_hand;
    string tg, tf;
    e_txd = tx_ser; e_rxs = rxd; e_txt = txt; e_rxt = rxt;
    e_ce = cpu_en; e_rdy = rdy; e_emt = emt; e_hand = 1;
    case (m_mode)
      1: begin e_txd = m_echo; e_txt = rxt; e_ce = 0; e_rdy = 0; e_emt = 0; end
      2: begin e_txd = 1; e_rxs = tx_ser; e_rxt = txt; end
      3: begin e_txd = m_echo; e_txt = rxt; e_hand = 0; end
      default: ;
    endcase
    case (m_mode)
      1: begin tg = brk ? "R8" : "R2"; tf = "R3"; end
      2: begin tg = "R4"; tf = "R4"; end
      3: begin tg = "R5"; tf = "R5"; end
      default: begin tg = "R1"; tf = "R1"; end
    endcase
    chk(txd_pin, e_txd, tg, "txd_pin");
    chk(tx_tick_o, e_txt, tg, "tx_tick_o");
    chk(rx_ser_o, e_rxs, tf, "rx_ser_o");
    chk(rx_tick_o, e_rxt, tf, "rx_tick_o");
    chk(cpu_tx_en_o, e_ce, tf, "cpu_tx_en_o");
    chk(tx_rdy_o, e_rdy, tf, "tx_rdy_o");
    chk(tx_emt_o, e_emt, tf, "tx_emt_o");
    chk(rx_hand_o, e_hand, (m_mode == 3) ? "R5" : tf, "rx_hand_o");
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cpu_en = 1; rdy = 1; emt = 1; tx_ser = 1; rxd = 1;
    repeat (3) @(negedge clk);
    // R7: reset state is normal routing
    chk(txd_pin, tx_ser, "R7", "txd_pin in reset");
    chk(rx_hand_o, 1'b1, "R7", "rx_hand_o in reset");
    chk(cpu_tx_en_o, 1'b1, "R7", "cpu_tx_en_o in reset");
    mode_req = 2'b01;
    rst_n = 1;
    cyc();
    // R6 idle lines: echo adopted at first edge; R7 echo level starts at mark
    chk(cpu_tx_en_o, 1'b0, "R6", "cpu_tx_en_o after idle switch");
    chk(txd_pin, 1'b1, "R7", "echo mark after reset");
    // R6 mid-frame request is deferred
    rxd = 0; rxt = 1; mode_req = 2'b00;
    cyc();
    rxt = 0; rxd = 1;
    cyc();
    chk(cpu_tx_en_o, 1'b0, "R6", "mode held during frame");
    for (int i = 0; i < FB - 1; i++) begin
      rxt = 1; cyc(); rxt = 0; cyc();
    end
    cyc();
    chk(cpu_tx_en_o, 1'b1, "R6", "mode applied after frame");
    // R8 break in echo
    mode_req = 2'b01; cyc(); cyc();
    brk = 1; rxd = 0;
    for (int i = 0; i < 40; i++) begin
      rxt = 1; cyc(); rxt = 0; cyc();
      chk(txd_pin, 1'b0, "R8", "break echoed");
    end
    rxd = 1;
    rxt = 1; cyc(); rxt = 0; cyc();
    chk(txd_pin, 1'b1, "R8", "break end echoed as mark");
    brk = 0;
    // random phase
    for (int c = 0; c < 60000; c++) begin
      rxt = (c % 4 == 0);
      txt = (c % 5 == 0);
      if (c % 4 == 2) begin
        if ((c / 2000) % 5 == 4) rxd = 0;
        else if ((c / 500) % 3 == 2) rxd = 1;
        else rxd = $urandom_range(0, 1);
      end
      if (c % 5 == 3) tx_ser = ((c / 700) % 4 == 3) ? 1'b1 : 1'(($urandom_range(0, 3)) != 0);
      cpu_en = $urandom_range(0, 1);
      rdy = $urandom_range(0, 1);
      emt = $urandom_range(0, 1);
      if ($urandom_range(0, 150) == 0) mode_req = 2'($urandom_range(0, 3));
      brk = (m_mode == 1) && ((c / 2000) % 5 == 4);
      cyc();
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule